// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. Two component predictors run side by side. A bimodal table of 2-bit counters is indexed by the branch address. A gshare table of 2-bit counters is indexed by a global direction history XORed with the address. A third table of 2-bit counters, the chooser, is indexed by the address and decides which of the two component answers becomes the final prediction. The chooser is trained only when the two components disagree about a resolved branch.

The front end presents an address on the predict port. In the same cycle it receives the final direction, both component directions and a history checkpoint. The checkpoint is the history value the lookup used. If the predict is valid, the history then shifts in the predicted direction speculatively. When the branch executes, the back end returns the address, the real outcome, the checkpoint and the two component directions on the resolve port. That trains the counters. If the back end also flags a misprediction, the history is rebuilt from the checkpoint plus the real outcome. The counter tables are written only at resolution, never speculatively.

Top module: `tourney_pred`

## Requirements
- R1: After reset the history is zero, every bimodal and gshare counter is 2'b10 (weakly taken) and every chooser counter is 2'b01, so a lookup reports pred_ckpt = 0 and pred_taken = pred_bim = pred_gsh = 1.
- R2: pred_taken equals pred_bim when the MSB of the selected chooser counter is 1, and equals pred_gsh when that MSB is 0. A component reports taken when its counter MSB is 1.
- R3: The gshare entry is the 12-bit history XORed with address bits [11:0]. The bimodal and chooser entries (9 bits each) are address bits [8:0] XORed with address bits [11:9] placed at bit positions [2:0].
- R4: pred_ckpt shows the history used by the current lookup. A valid predict without repair makes the next history {pred_ckpt[10:0], pred_taken}.
- R5: In a cycle with neither a valid predict nor a repair, the history keeps its value.
- R6: The bimodal and gshare counters are written only by a valid resolve, stepping toward res_taken. The bimodal counter is indexed by res_addr and the gshare counter by res_ckpt XOR res_addr. Predict lookups write nothing.
- R7: On a valid resolve, the chooser counter at res_addr increments when res_bim matched res_taken and res_gsh did not. It decrements in the opposite case. Otherwise it is left unchanged.
- R8: A resolve with res_mispred = 1 sets the history to {res_ckpt[10:0], res_taken}. A resolve with res_mispred = 0 does not change the history.
- R9: When a repair and a valid predict happen in the same cycle, the lookup uses the repaired history (pred_ckpt = {res_ckpt[10:0], res_taken}). The next history is that value shifted by pred_taken.
- R10: A counter trained by a resolve shows its new value from the next cycle on. A lookup in the same cycle sees the old value.
- R11: All counters saturate: incrementing 2'b11 and decrementing 2'b00 leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Lookup is a real fetch; shifts the history |
| pred_addr | input | HIST_W | Branch address for the lookup |
| pred_taken | output | 1 | Final predicted direction |
| pred_bim | output | 1 | Bimodal component direction |
| pred_gsh | output | 1 | Gshare component direction |
| pred_ckpt | output | HIST_W | History used by this lookup |
| res_valid | input | 1 | A branch resolves this cycle |
| res_addr | input | HIST_W | Address of the resolving branch |
| res_taken | input | 1 | Actual direction |
| res_ckpt | input | HIST_W | Checkpoint returned with its prediction |
| res_bim | input | 1 | Bimodal direction given at prediction |
| res_gsh | input | 1 | Gshare direction given at prediction |
| res_mispred | input | 1 | Final prediction was wrong; repair history |

## Verification
The history properties assume that res_mispred is asserted only together with res_valid. The bench never raises it alone. The checks also assume that res_ckpt, res_bim and res_gsh are values the block itself produced. The bench uses consistent values wherever the history is compared against a prediction. Where the bench feeds arbitrary component directions, it does so only to steer the chooser. The properties rely on nothing else from those inputs.

// File: rtl/tgp_pkg.sv
package tgp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'b01;
  localparam ctr2_t CTR_WEAK_T  = 2'b10;

  // saturating one-step move of a 2-bit counter
  function automatic ctr2_t ctr_step(ctr2_t c, logic up);
    ctr2_t r;
    if (up) r = (c == 2'b11) ? c : c + 2'b01;
    else    r = (c == 2'b00) ? c : c - 2'b01;
    return r;
  endfunction
endpackage

// File: rtl/ctr_table.sv
module ctr_table
  import tgp_pkg::*;
#(
  parameter int    IDX_W   = 9,
  parameter ctr2_t RST_VAL = CTR_WEAK_T
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_dir,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t cell_q [DEPTH];
  ctr2_t wr_nxt;

  always_comb begin
    wr_nxt = ctr_step(cell_q[wr_idx], wr_up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= RST_VAL;
    end else if (wr_en) begin
      cell_q[wr_idx] <= wr_nxt;
    end
  end

  assign rd_dir = cell_q[rd_idx][1];
endmodule

// File: rtl/ghist_reg.sv
module ghist_reg #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_fire,
  input  logic              pred_dir,
  input  logic              fix_en,
  input  logic [HIST_W-1:0] fix_ckpt,
  input  logic              fix_dir,
  output logic [HIST_W-1:0] hist_eff
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;
  logic              hist_en;

  // repair overrides the stored value for this cycle's lookup
  assign hist_eff = fix_en ? {fix_ckpt[HIST_W-2:0], fix_dir} : hist_q;

  always_comb begin
    hist_en = pred_fire | fix_en;
    hist_d  = pred_fire ? {hist_eff[HIST_W-2:0], pred_dir} : hist_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (hist_en) hist_q <= hist_d;
  end
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tgp_pkg::*;
#(
  parameter int HIST_W = 12,
  parameter int BIM_W  = 9,
  parameter int CHO_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  input  logic [HIST_W-1:0] pred_addr,
  output logic              pred_taken,
  output logic              pred_bim,
  output logic              pred_gsh,
  output logic [HIST_W-1:0] pred_ckpt,
  input  logic              res_valid,
  input  logic [HIST_W-1:0] res_addr,
  input  logic              res_taken,
  input  logic [HIST_W-1:0] res_ckpt,
  input  logic              res_bim,
  input  logic              res_gsh,
  input  logic              res_mispred
);
  // fold address bits above the table width back onto the low bits
  function automatic logic [BIM_W-1:0] fold_bim(logic [HIST_W-1:0] a);
    return a[BIM_W-1:0] ^ BIM_W'(a >> BIM_W);
  endfunction
  function automatic logic [CHO_W-1:0] fold_cho(logic [HIST_W-1:0] a);
    return a[CHO_W-1:0] ^ CHO_W'(a >> CHO_W);
  endfunction

  logic              repair;
  logic [HIST_W-1:0] hist_eff;
  logic [HIST_W-1:0] gsh_rd_idx, gsh_wr_idx;
  logic [BIM_W-1:0]  bim_rd_idx, bim_wr_idx;
  logic [CHO_W-1:0]  cho_rd_idx, cho_wr_idx;
  logic              bim_dir, gsh_dir, cho_dir;
  logic              bim_ok, gsh_ok, cho_wr_en;

  always_comb begin
    repair     = res_valid & res_mispred;
    gsh_rd_idx = hist_eff ^ pred_addr;
    gsh_wr_idx = res_ckpt ^ res_addr;
    bim_rd_idx = fold_bim(pred_addr);
    bim_wr_idx = fold_bim(res_addr);
    cho_rd_idx = fold_cho(pred_addr);
    cho_wr_idx = fold_cho(res_addr);
    bim_ok     = (res_bim == res_taken);
    gsh_ok     = (res_gsh == res_taken);
    cho_wr_en  = res_valid & (bim_ok ^ gsh_ok);
  end

  ctr_table #(.IDX_W(BIM_W), .RST_VAL(CTR_WEAK_T)) u_bim (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(bim_rd_idx), .rd_dir(bim_dir),
    .wr_en(res_valid), .wr_idx(bim_wr_idx), .wr_up(res_taken)
  );

  ctr_table #(.IDX_W(HIST_W), .RST_VAL(CTR_WEAK_T)) u_gsh (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(gsh_rd_idx), .rd_dir(gsh_dir),
    .wr_en(res_valid), .wr_idx(gsh_wr_idx), .wr_up(res_taken)
  );

  // chooser MSB high favours the bimodal component
  ctr_table #(.IDX_W(CHO_W), .RST_VAL(CTR_WEAK_NT)) u_cho (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(cho_rd_idx), .rd_dir(cho_dir),
    .wr_en(cho_wr_en), .wr_idx(cho_wr_idx), .wr_up(bim_ok)
  );

  ghist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .pred_fire(pred_valid), .pred_dir(pred_taken),
    .fix_en(repair), .fix_ckpt(res_ckpt), .fix_dir(res_taken),
    .hist_eff(hist_eff)
  );

  assign pred_bim   = bim_dir;
  assign pred_gsh   = gsh_dir;
  assign pred_taken = cho_dir ? bim_dir : gsh_dir;
  assign pred_ckpt  = hist_eff;
endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
  parameter int HIST_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic              pred_bim,
  input logic              pred_gsh,
  input logic [HIST_W-1:0] pred_ckpt,
  input logic              res_valid,
  input logic              res_taken,
  input logic [HIST_W-1:0] res_ckpt,
  input logic              res_mispred
);
  logic armed;
  logic fix;

  assign fix = res_valid & res_mispred;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2: when both components agree the final answer follows them
  a_r2_agree_select: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_bim == pred_gsh) |-> (pred_taken == pred_bim));

  // R4: a fetched prediction shifts its own direction into the history
  a_r4_spec_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pred_valid && !fix) && !fix)
      |-> (pred_ckpt == {$past(pred_ckpt[HIST_W-2:0]), $past(pred_taken)}));

  // R5: idle cycles keep the history
  a_r5_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!pred_valid && !fix) && !fix)
      |-> (pred_ckpt == $past(pred_ckpt)));

  // R8: repair rebuilds the history from checkpoint and outcome
  a_r8_repair: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(fix && !pred_valid) && !fix)
      |-> (pred_ckpt == {$past(res_ckpt[HIST_W-2:0]), $past(res_taken)}));

  // R9: a repair in the lookup cycle wins over the stored history
  a_r9_repair_first: assert property (@(posedge clk) disable iff (!rst_n)
    fix |-> (pred_ckpt == {res_ckpt[HIST_W-2:0], res_taken}));
endmodule

bind tourney_pred tourney_pred_chk #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid),
  .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
  .pred_ckpt(pred_ckpt), .res_valid(res_valid), .res_taken(res_taken),
  .res_ckpt(res_ckpt), .res_mispred(res_mispred)
);

// File: tb/sim_tourney_pred.sv
module sim_tourney_pred;
  localparam int HW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pred_valid;
  logic [HW-1:0] pred_addr;
  logic          pred_taken, pred_bim, pred_gsh;
  logic [HW-1:0] pred_ckpt;
  logic          res_valid;
  logic [HW-1:0] res_addr;
  logic          res_taken;
  logic [HW-1:0] res_ckpt;
  logic          res_bim, res_gsh, res_mispred;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  tourney_pred u0 (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_addr(pred_addr),
    .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
    .pred_ckpt(pred_ckpt),
    .res_valid(res_valid), .res_addr(res_addr), .res_taken(res_taken),
    .res_ckpt(res_ckpt), .res_bim(res_bim), .res_gsh(res_gsh),
    .res_mispred(res_mispred)
  );

  typedef struct packed {
    logic pv; logic [HW-1:0] pa;
    logic rv; logic [HW-1:0] ra; logic rt; logic [HW-1:0] rc;
    logic rb; logic rg; logic rm;
    logic et; logic eb; logic [HW-1:0] ec;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{1'b1, 12'h005, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000},
    '{1'b1, 12'h005, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h001},
    '{1'b0, 12'h005, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h003},
    '{1'b0, 12'h005, 1'b1, 12'h005, 1'b0, 12'h000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000},
    '{1'b1, 12'h005, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000},
    '{1'b1, 12'h005, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000},
    '{1'b0, 12'h007, 1'b1, 12'h007, 1'b1, 12'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000},
    '{1'b0, 12'h007, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of inputs at the falling edge, settle, then sample
  task automatic apply(input logic pv, input logic [HW-1:0] pa,
                       input logic rv, input logic [HW-1:0] ra, input logic rt,
                       input logic [HW-1:0] rc, input logic rb, input logic rg,
                       input logic rm);
    @(negedge clk);
    pred_valid = pv; pred_addr = pa;
    res_valid = rv; res_addr = ra; res_taken = rt; res_ckpt = rc;
    res_bim = rb; res_gsh = rg; res_mispred = rm;
    #1;
  endtask

  task automatic idle(input logic [HW-1:0] pa);
    apply(1'b0, pa, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pred_valid = 1'b0; pred_addr = '0;
    res_valid = 1'b0; res_addr = '0; res_taken = 1'b0; res_ckpt = '0;
    res_bim = 1'b0; res_gsh = 1'b0; res_mispred = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ckpt", pred_ckpt, 0);
    chk("R1 taken", pred_taken, 1);
    chk("R1 bim", pred_bim, 1);
    chk("R1 gsh", pred_gsh, 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();

    // vector table: R4 R5 R6 R8 R10
    for (int i = 0; i < 8; i++) begin
      apply(VT[i].pv, VT[i].pa, VT[i].rv, VT[i].ra, VT[i].rt, VT[i].rc,
            VT[i].rb, VT[i].rg, VT[i].rm);
      chk($sformatf("R4/R6/R10 row%0d ckpt", i), pred_ckpt, VT[i].ec);
      chk($sformatf("R6/R10 row%0d taken", i), pred_taken, VT[i].et);
      chk($sformatf("R6 row%0d bim", i), pred_bim, VT[i].eb);
    end

    do_reset();
    // train bimodal down while gshare trains another entry
    repeat (2) apply(1'b0, 12'h010, 1'b1, 12'h010, 1'b0, 12'h100, 1'b1, 1'b1, 1'b0);
    idle(12'h010);
    chk("R3 bim", pred_bim, 0);
    chk("R3 gsh", pred_gsh, 1);
    chk("R2 gshare chosen", pred_taken, 1);
    // bimodal right, gshare wrong: chooser moves to bimodal
    apply(1'b0, 12'h010, 1'b1, 12'h010, 1'b0, 12'h200, 1'b0, 1'b1, 1'b0);
    idle(12'h010);
    chk("R7/R2 bimodal chosen", pred_taken, 0);
    // repair, then lookup reads gshare at 0x100 ^ 0x010
    apply(1'b0, 12'h010, 1'b1, 12'h3F0, 1'b0, 12'h080, 1'b1, 1'b1, 1'b1);
    chk("R9 repair visible same cycle", pred_ckpt, 12'h100);
    idle(12'h010);
    chk("R8 repaired hist", pred_ckpt, 12'h100);
    chk("R3 xor index", pred_gsh, 0);
    apply(1'b0, 12'h010, 1'b1, 12'h3F0, 1'b1, 12'h555, 1'b1, 1'b1, 1'b0);
    idle(12'h010);
    chk("R8 no-mispred resolve keeps hist", pred_ckpt, 12'h100);
    apply(1'b1, 12'h010, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk("R4 ckpt pre-shift", pred_ckpt, 12'h100);
    chk("R2 taken", pred_taken, 0);
    idle(12'h010);
    chk("R4 shifted", pred_ckpt, 12'h200);
    idle(12'h010);
    chk("R5 hold", pred_ckpt, 12'h200);
    apply(1'b1, 12'h020, 1'b1, 12'h3E0, 1'b1, 12'h001, 1'b1, 1'b1, 1'b1);
    chk("R9 ckpt", pred_ckpt, 12'h003);
    chk("R9 taken", pred_taken, 1);
    idle(12'h020);
    chk("R9 next hist", pred_ckpt, 12'h007);

    do_reset();
    repeat (3) apply(1'b0, 12'h010, 1'b1, 12'h010, 1'b0, 12'h100, 1'b1, 1'b1, 1'b0);
    repeat (2) apply(1'b0, 12'h010, 1'b1, 12'h010, 1'b1, 12'h300, 1'b0, 1'b0, 1'b0);
    idle(12'h010);
    chk("R11 low saturation", pred_bim, 1);
    repeat (3) apply(1'b0, 12'h020, 1'b1, 12'h020, 1'b1, 12'h000, 1'b1, 1'b1, 1'b0);
    apply(1'b0, 12'h020, 1'b1, 12'h020, 1'b0, 12'h000, 1'b1, 1'b1, 1'b0);
    idle(12'h020);
    chk("R11 high saturation", pred_gsh, 1);
    repeat (2) apply(1'b0, 12'h030, 1'b1, 12'h030, 1'b0, 12'h400, 1'b1, 1'b0, 1'b0);
    apply(1'b0, 12'h030, 1'b1, 12'h030, 1'b0, 12'h400, 1'b0, 1'b1, 1'b0);
    idle(12'h030);
    chk("R7 chooser dec then inc bim", pred_bim, 0);
    chk("R7 chooser dec then inc", pred_taken, 1);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule